// File: doc/BRIEF.md
# Auto-Reload Down Timer with Square-Wave Output

This block is a parameterised down-counting timer. A reload register, loaded through a data bus with a write strobe, holds the start value. While the enable input is high the counter runs down to zero. On the following clock it returns to the reload value and raises a one-cycle interrupt-source pulse. The same pulse clocks a divide-by-two stage, which gives a 50% duty square wave at half the pulse rate.

When enable is low the timer is idle. The counter is frozen and both outputs are held low, but the reload register keeps its contents. A write while running restarts the count at once from the new value. Two boundary cases have defined behaviour:

- A write in the final cycle before a pulse does not suppress that pulse.
- A disable in that same cycle emits the pulse immediately and also stores it. The stored event is issued again when the timer is next enabled.

All outputs are registered.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, and for as long as enable stays low (apart from the R8 case), `irq` and `fout` are 0. Writes made while idle produce no pulse.
- R2: When enable is sampled high at edge E0, counting starts from the reload value R. `irq` is 1 after edge E(k) exactly when k is a positive multiple of R+1. With R=0 it pulses after every edge.
- R3: Each `irq` pulse lasts one cycle when R is 1 or more.
- R4: `fout` is 0 after the enabling edge and toggles on every reload pulse. After E(k) it equals floor(k/(R+1)) mod 2.
- R5: A write at edge Ew while running restarts the count from the written value W. The next pulse follows edge Ew+W+1.
- R6: A write at the edge on which a pulse is due does not cancel that pulse. The following period uses the written value.
- R7: Sampling enable low drives `fout` low after that edge. The reload register keeps its value, so re-enabling without a write again gives period R+1. A disable at any other edge leaves no stored event.
- R8: If enable is sampled low at the edge on which a pulse is due, `irq` is 1 after that edge and the event is stored. On the next enabling edge `irq` is 1 again, even if the reload register was rewritten while idle.
- R9: If a write and the enabling edge coincide, the written value is the first count start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run (1) or idle (0) |
| wr | input | 1 | Reload register write strobe |
| wdata | input | WIDTH | Reload value to write |
| irq | output | 1 | One-cycle interrupt-source pulse |
| fout | output | 1 | Divide-by-two square wave |

## Verification
Every result is one register away from the edge that causes it. A pulse for reload value R appears just after edge E(R+1), counted from the enabling edge E0. A write at edge Ew moves the next pulse to just after Ew+W+1. Disable and replay effects show right after the edge that samples the change.

The bench drives inputs and samples outputs 1 ns after each rising edge. It computes the expected values from the edge index by modular arithmetic and sweeps every reload value from 0 to 255. Directed runs cover restart, a write in the final cycle, disable, replay and a write coinciding with enable.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
   typedef enum logic {
      RT_IDLE = 1'b0,
      RT_RUN  = 1'b1
   } rt_mode_e;
endpackage

// File: rtl/rtim_count.sv
module rtim_count #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             go,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] reload,
   output logic             zero
);
   localparam logic [WIDTH-1:0] CNT_ZERO = '0;
   localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= CNT_ZERO;
      end else if (start) begin
         // a write on the enabling edge takes precedence over the stored value
         cnt <= wr ? wdata : reload;
      end else if (go) begin
         if (wr)
            cnt <= wdata;
         else if (cnt == CNT_ZERO)
            cnt <= reload;
         else
            cnt <= cnt - CNT_ONE;
      end
   end

   assign zero = (cnt == CNT_ZERO);
endmodule

// File: rtl/rtim_event.sv
module rtim_event #(
   parameter bit REPLAY = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic start,
   input  logic ev,
   output logic irq
);
   logic held;

   generate
      if (REPLAY) begin : g_hold
         logic held_q;
         always_ff @(posedge clk) begin
            if (rst)
               held_q <= 1'b0;
            else if (start)
               held_q <= 1'b0;
            else if (!en)
               held_q <= held_q | ev;
         end
         assign held = held_q;
      end else begin : g_nohold
         assign held = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         irq <= 1'b0;
      else if (en)
         irq <= ev | (start & held);
      else
         irq <= ev;
   end
endmodule

// File: rtl/rtim_div2.sv
module rtim_div2 (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic start,
   input  logic ev,
   output logic fout
);
   always_ff @(posedge clk) begin
      if (rst || !en || start)
         fout <= 1'b0;
      else if (ev)
         fout <= ~fout;
   end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
   parameter int WIDTH  = 8,
   parameter bit REPLAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   output logic             irq,
   output logic             fout
);
   import rtim_pkg::*;

   localparam logic [WIDTH-1:0] RELOAD_INIT = '0;

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("reload_timer: WIDTH must lie in 2..32");
      end
   endgenerate

   rt_mode_e         mode;
   logic [WIDTH-1:0] reload;
   logic             start;
   logic             go;
   logic             zero;
   logic             ev;

   always_ff @(posedge clk) begin
      if (rst)
         mode <= RT_IDLE;
      else
         mode <= en ? RT_RUN : RT_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst)
         reload <= RELOAD_INIT;
      else if (wr)
         reload <= wdata;
   end

   assign start = en && (mode == RT_IDLE);
   assign go    = en && (mode == RT_RUN);
   assign ev    = (mode == RT_RUN) && zero;

   rtim_count #(.WIDTH(WIDTH)) u_count (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .go     (go),
      .wr     (wr),
      .wdata  (wdata),
      .reload (reload),
      .zero   (zero)
   );

   rtim_event #(.REPLAY(REPLAY)) u_event (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .start (start),
      .ev    (ev),
      .irq   (irq)
   );

   rtim_div2 u_div2 (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .start (start),
      .ev    (ev),
      .fout  (fout)
   );
endmodule

// File: rtl/rtim_checks.sv
module rtim_checks (
   input logic clk,
   input logic rst,
   input logic en,
   input logic irq,
   input logic fout
);
   // R1: reset clears both outputs on the next edge
   a_r1_reset_low: assert property (@(posedge clk) rst |=> (!irq && !fout));

   // R1: two consecutive idle samples give no pulse
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!en && !$past(en)) |=> !irq);

   // R4: the square wave rises only together with a reload pulse
   a_r4_fout_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(fout) |-> irq);

   // R7: disabling forces the square wave low
   a_r7_fout_low: assert property (@(posedge clk) disable iff (rst)
      !en |=> !fout);
endmodule

bind reload_timer rtim_checks u_chk (
   .clk  (clk),
   .rst  (rst),
   .en   (en),
   .irq  (irq),
   .fout (fout)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic       irq;
   logic       fout;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   reload_timer #(.WIDTH(8)) dut (
      .clk(clk), .rst(rst), .en(en), .wr(wr), .wdata(wdata),
      .irq(irq), .fout(fout)
   );

   always #10 clk = ~clk;

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; en = 1'b0; wr = 1'b0;
      step();
      rst = 1'b0;
   endtask

   task automatic load_idle(int v);
      wr = 1'b1; wdata = v[7:0];
      step();
      wr = 1'b0;
   endtask

   task automatic sweep(int r);
      do_reset();
      load_idle(r);
      en = 1'b1;
      step();                       // edge E0
      chk("R2 irq at enable", irq, 1'b0);
      chk("R4 fout at enable", fout, 1'b0);
      for (int k = 1; k <= 2 * (r + 1); k++) begin
         step();
         chk("R2 R3 irq period", irq, (k % (r + 1)) == 0);
         chk("R4 fout toggle", fout, ((k / (r + 1)) % 2) == 1);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step(); step();
      rst = 1'b0;
      // R1: reset state and idle with writes
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 fout after reset", fout, 1'b0);
      load_idle(0);
      for (int i = 0; i < 20; i++) begin
         step();
         chk("R1 idle irq", irq, 1'b0);
         chk("R1 idle fout", fout, 1'b0);
      end

      // R2 R3 R4: every reload value
      for (int r = 0; r < 256; r++) sweep(r);

      // R5: restart on write while running
      do_reset();
      load_idle(10);
      en = 1'b1; step();            // E0
      step(); step(); step();       // E1..E3
      wr = 1'b1; wdata = 8'd3; step(); wr = 1'b0;  // E4
      chk("R5 no pulse at write", irq, 1'b0);
      for (int k = 5; k <= 8; k++) begin
         step();
         chk("R5 restart pulse", irq, k == 8);
      end
      chk("R5 fout after first pulse", fout, 1'b1);

      // R6: write at the pulse edge keeps the pulse
      do_reset();
      load_idle(5);
      en = 1'b1; step();            // E0
      for (int k = 1; k <= 5; k++) step();
      wr = 1'b1; wdata = 8'd2; step(); wr = 1'b0;  // E6
      chk("R6 pulse kept", irq, 1'b1);
      step(); chk("R6 next period", irq, 1'b0);
      step(); chk("R6 next period", irq, 1'b0);
      step(); chk("R6 new value pulse", irq, 1'b1);

      // R7: disable mid-count, register kept, nothing stored
      do_reset();
      load_idle(4);
      en = 1'b1; step();
      step(); step(); step();
      en = 1'b0; step();
      chk("R7 fout low", fout, 1'b0);
      chk("R7 irq low", irq, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R7 idle irq", irq, 1'b0);
      end
      en = 1'b1; step();            // E0
      chk("R7 no replay", irq, 1'b0);
      for (int k = 1; k <= 5; k++) begin
         step();
         chk("R7 kept register period", irq, k == 5);
      end

      // R8: disable at pulse edge, rewrite while idle, replay
      do_reset();
      load_idle(3);
      en = 1'b1; step();
      step(); step(); step();       // E1..E3
      en = 1'b0; step();            // E4 pulse due
      chk("R8 extra pulse", irq, 1'b1);
      chk("R8 fout low", fout, 1'b0);
      step(); chk("R8 idle after extra", irq, 1'b0);
      load_idle(5);
      chk("R8 idle write", irq, 1'b0);
      en = 1'b1; step();            // Ex
      chk("R8 replay", irq, 1'b1);
      chk("R8 fout at enable", fout, 1'b0);
      for (int k = 1; k <= 6; k++) begin
         step();
         chk("R8 period after replay", irq, k == 6);
      end
      chk("R8 fout first pulse", fout, 1'b1);

      // R9: write coinciding with enable
      do_reset();
      load_idle(7);
      en = 1'b1; wr = 1'b1; wdata = 8'd2; step(); wr = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         step();
         chk("R9 write first", irq, k == 3);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule